// File: doc/BRIEF.md
# Per-Core Mailbox Doorbell Bank

This block holds a bank of doorbell words that processor cores use to signal one another. There are four cores with four mailboxes each, sixteen words in all. Each mailbox can be reached through two addresses on a simple 32-bit register bus. A write to the first address ORs the written word into the mailbox. A write to the second address clears every bit of the mailbox that is 1 in the written word.

Every mailbox drives its own level interrupt line. The line stays high as long as at least one bit of that mailbox is 1. The sixteen lines go to a separate interrupt router, which handles masking and steering. A receiving core reads its mailbox, picks the lowest set bit, and writes that bit back to the clear address to acknowledge it. Either address of a mailbox returns its current contents on a read.

Mailbox numbers count first within a core and then across cores. Mailbox `m` of core `c` has flat index `i = 4*c + m`, and `irq_o[i]` is its interrupt line. The widths, the counts and the two window bases are parameters.

Top module: `mbx_doorbell_bank`

## Requirements
- R1: After reset every mailbox holds zero, every bit of `irq_o` is 0, and `bus_rdata` is 0.
- R2: The set address of mailbox `m` of core `c` is 0x80 + 16*c + 4*m, and its clear address is 0xC0 + 16*c + 4*m. Flat index `4*c + m` selects the mailbox and its bit of `irq_o`. A single access hits at most one window.
- R3: A write (`bus_wr`=1) to a set address replaces the mailbox with its old value ORed with `bus_wdata`. The new value is visible from the cycle after the write edge.
- R4: A write to a clear address replaces the mailbox with its old value ANDed with the inverse of `bus_wdata`. Bits written as 0 keep their value.
- R5: `irq_o[i]` is 1 exactly when mailbox `i` is nonzero. A line can only fall in the cycle after a write to a clear address.
- R6: A read (`bus_rd`=1) of a clear address loads the mailbox contents into `bus_rdata` at that clock edge. The value held is the one from before any write in the same cycle, and it stays until the next read.
- R7: A read of a set address returns the mailbox contents in the same way as R6.
- R8: A write to an address outside both windows, or to an address whose two low bits are not zero, changes no mailbox. A read of such an address returns 0.
- R9: A write to one mailbox leaves every other mailbox unchanged. A mailbox with no write in a cycle keeps its value.
- R10: Reads have no side effect on the mailbox contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| irq_o | output | 16 | Level interrupt per mailbox, index `4*core + mailbox` |

## Verification
The case that is hardest to reach from the ports is a mailbox that stays partly set while its neighbours are written. Such a mailbox shows up only as a level that must not move. To reach it, the stimulus first fills every mailbox with a distinct pattern that depends on its index. It then ORs a second pattern on top and clears a different subset of bits, one mailbox at a time. After every single write the whole 16-bit interrupt vector is compared, and all contents are read back through both addresses. Stray writes at misaligned and out-of-window addresses are then sent with all-ones data, and the full bank is read again to show that nothing moved.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Operation selected by one bus write to one mailbox.
   typedef enum logic [1:0] {
      MBX_OP_NONE = 2'd0,
      MBX_OP_SET  = 2'd1,
      MBX_OP_CLR  = 2'd2
   } mbx_op_e;

   // Smallest index width able to name n entries (at least one bit).
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned N_MBX       = 16,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned WORD_BYTES  = 4,
   parameter int unsigned SET_BASE    = 32'h80,
   parameter int unsigned CLR_BASE    = 32'hC0,
   parameter bit          ALIGN_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              set_hit,
   output logic              clr_hit,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned SPAN = N_MBX * WORD_BYTES;
   localparam int unsigned LSB  = $clog2(WORD_BYTES);

   logic [31:0] a32;
   logic [31:0] off_set;
   logic [31:0] off_clr;
   logic        in_set;
   logic        in_clr;
   logic        aligned;

   assign a32     = 32'(addr);
   assign off_set = a32 - SET_BASE;
   assign off_clr = a32 - CLR_BASE;
   assign in_set  = (a32 >= SET_BASE) && (a32 < SET_BASE + SPAN);
   assign in_clr  = (a32 >= CLR_BASE) && (a32 < CLR_BASE + SPAN);

   // Variant: strict word alignment, or byte lanes folded onto the word.
   generate
      if (ALIGN_CHECK) begin : g_strict
         assign aligned = (a32 & 32'(WORD_BYTES - 1)) == 32'd0;
      end else begin : g_loose
         assign aligned = 1'b1;
      end
   endgenerate

   assign set_hit = in_set && aligned;
   assign clr_hit = in_clr && aligned;

   always_comb begin
      if (in_set) idx = IDX_W'(off_set >> LSB);
      else        idx = IDX_W'(off_clr >> LSB);
   end

   // The two windows must never both claim an access.
   property p_onehot;
      @(posedge clk) disable iff (!rst_n) $onehot0({set_hit, clr_hit});
   endproperty
   assert_one_window_R2: assert property (p_onehot);

   // A hit always names a mailbox that exists.
   property p_idx_range;
      @(posedge clk) disable iff (!rst_n)
         (set_hit || clr_hit) |-> (32'(idx) < N_MBX);
   endproperty
   assert_idx_range_R2: assert property (p_idx_range);

endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] word_o,
   output logic              irq_o
);

   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] word_d;

   // Set takes priority over clear for a bit named by both.
   assign word_d = (word_q & ~clr_mask) | set_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign word_o = word_q;
   assign irq_o  = |word_q;

   property p_set;
      @(posedge clk) disable iff (!rst_n)
         (set_mask != '0) |=> ((word_o & $past(set_mask)) == $past(set_mask));
   endproperty
   assert_set_bits_R3: assert property (p_set);

   property p_clr;
      @(posedge clk) disable iff (!rst_n)
         ((clr_mask & ~set_mask) != '0) |=> ((word_o & $past(clr_mask & ~set_mask)) == '0);
   endproperty
   assert_clear_bits_R4: assert property (p_clr);

   property p_keep;
      @(posedge clk) disable iff (!rst_n)
         (clr_mask == '0) |=> ((word_o & $past(word_o)) == $past(word_o));
   endproperty
   assert_no_loss_R4: assert property (p_keep);

   property p_hold;
      @(posedge clk) disable iff (!rst_n)
         ((set_mask == '0) && (clr_mask == '0)) |=> $stable(word_o);
   endproperty
   assert_hold_R9: assert property (p_hold);

endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned N_MBX  = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  logic                         hit,
   input  logic [IDX_W-1:0]             idx,
   input  logic [N_MBX-1:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0]            rdata
);

   logic [DATA_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int k = 0; k < N_MBX; k++) begin
         if (hit && (idx == IDX_W'(k))) sel_word = words[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel_word;
   end

   property p_miss;
      @(posedge clk) disable iff (!rst_n) (rd_en && !hit) |=> (rdata == '0);
   endproperty
   assert_miss_zero_R8: assert property (p_miss);

   property p_hold;
      @(posedge clk) disable iff (!rst_n) !rd_en |=> $stable(rdata);
   endproperty
   assert_rdata_hold_R6: assert property (p_hold);

endmodule

// File: rtl/mbx_doorbell_bank.sv
module mbx_doorbell_bank #(
   parameter int unsigned N_CORES     = 4,
   parameter int unsigned MB_PER_CORE = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SET_BASE    = 32'h80,
   parameter int unsigned CLR_BASE    = 32'hC0,
   parameter bit          ALIGN_CHECK = 1'b1,
   localparam int unsigned N_MBX      = N_CORES * MB_PER_CORE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_MBX-1:0]  irq_o
);

   import mbx_pkg::*;

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned IDX_W      = idx_width(N_MBX);
   localparam int unsigned SPAN       = N_MBX * WORD_BYTES;

   // Elaboration-time parameter checks.
   generate
      if ((DATA_W % 8) != 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0)
         $error("mbx_doorbell_bank: DATA_W must be a power-of-two number of bytes");
      if (N_MBX < 1)
         $error("mbx_doorbell_bank: need at least one mailbox");
      if (!((SET_BASE + SPAN <= CLR_BASE) || (CLR_BASE + SPAN <= SET_BASE)))
         $error("mbx_doorbell_bank: set and clear windows overlap");
      if ((SET_BASE + SPAN > (64'd1 << ADDR_W)) || (CLR_BASE + SPAN > (64'd1 << ADDR_W)))
         $error("mbx_doorbell_bank: a window does not fit the address width");
      if ((SET_BASE % WORD_BYTES) != 0 || (CLR_BASE % WORD_BYTES) != 0)
         $error("mbx_doorbell_bank: window bases must be word aligned");
   endgenerate

   logic                         set_hit;
   logic                         clr_hit;
   logic [IDX_W-1:0]             idx;
   logic [N_MBX-1:0][DATA_W-1:0] words;
   mbx_op_e                      op;

   mbx_decode #(
      .ADDR_W      (ADDR_W),
      .N_MBX       (N_MBX),
      .IDX_W       (IDX_W),
      .WORD_BYTES  (WORD_BYTES),
      .SET_BASE    (SET_BASE),
      .CLR_BASE    (CLR_BASE),
      .ALIGN_CHECK (ALIGN_CHECK)
   ) u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .set_hit (set_hit),
      .clr_hit (clr_hit),
      .idx     (idx)
   );

   always_comb begin
      if (!bus_wr)      op = MBX_OP_NONE;
      else if (set_hit) op = MBX_OP_SET;
      else if (clr_hit) op = MBX_OP_CLR;
      else              op = MBX_OP_NONE;
   end

   generate
      for (genvar i = 0; i < N_MBX; i++) begin : g_mbx
         logic              sel;
         logic [DATA_W-1:0] set_mask;
         logic [DATA_W-1:0] clr_mask;

         assign sel      = (idx == IDX_W'(i));
         assign set_mask = (sel && op == MBX_OP_SET) ? bus_wdata : '0;
         assign clr_mask = (sel && op == MBX_OP_CLR) ? bus_wdata : '0;

         mbx_cell #(.DATA_W(DATA_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask),
            .clr_mask (clr_mask),
            .word_o   (words[i]),
            .irq_o    (irq_o[i])
         );
      end
   endgenerate

   mbx_rdmux #(
      .DATA_W (DATA_W),
      .N_MBX  (N_MBX),
      .IDX_W  (IDX_W)
   ) u_rdmux (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (bus_rd),
      .hit   (set_hit || clr_hit),
      .idx   (idx),
      .words (words),
      .rdata (bus_rdata)
   );

   // Lines only drop after a clear-window write.
   property p_no_fall;
      @(posedge clk) disable iff (!rst_n)
         !(bus_wr && clr_hit) |=> (($past(irq_o) & ~irq_o) == '0);
   endproperty
   assert_irq_no_fall_R5: assert property (p_no_fall);

   // Lines only rise after a set-window write.
   property p_no_rise;
      @(posedge clk) disable iff (!rst_n)
         !(bus_wr && set_hit) |=> ((irq_o & ~$past(irq_o)) == '0);
   endproperty
   assert_irq_no_rise_R5: assert property (p_no_rise);

   // Misses never disturb the interrupt vector.
   property p_miss_write;
      @(posedge clk) disable iff (!rst_n)
         (bus_wr && !set_hit && !clr_hit) |=> $stable(irq_o);
   endproperty
   assert_miss_write_R8: assert property (p_miss_write);

   property p_reset;
      @(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> ((irq_o == '0) && (bus_rdata == '0));
   endproperty
   assert_reset_clear_R1: assert property (p_reset);

endmodule

// File: tb/mbx_doorbell_bank_tb.sv
`timescale 1ns/1ps
module mbx_doorbell_bank_tb;

   localparam int NM = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] mdl [NM];

   always #4 clk = ~clk;

   mbx_doorbell_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   function automatic logic [7:0] set_adr(int i);
      return 8'(32'h80 + 16 * (i / 4) + 4 * (i % 4));
   endfunction
   function automatic logic [7:0] clr_adr(int i);
      return 8'(32'hC0 + 16 * (i / 4) + 4 * (i % 4));
   endfunction
   function automatic logic [15:0] exp_irq();
      logic [15:0] v;
      for (int k = 0; k < NM; k++) v[k] = (mdl[k] != 0);
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic check_all(string req);
      logic [31:0] d;
      chk({req, " irq vector"}, 32'(irq_o), 32'(exp_irq()));
      for (int k = 0; k < NM; k++) begin
         rd(clr_adr(k), d);
         chk({req, " R6 clear-address read"}, d, mdl[k]);
         rd(set_adr(k), d);
         chk({req, " R7 set-address read"}, d, mdl[k]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] p;
      for (int k = 0; k < NM; k++) mdl[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 irq after reset", 32'(irq_o), 32'h0);
      chk("R1 rdata after reset", bus_rdata, 32'h0);
      check_all("R1");

      // R2 R3 R9: fill each mailbox in turn, whole vector checked each time
      for (int i = 0; i < NM; i++) begin
         p = (32'h1 << i) | (32'(i + 1) << 24);
         wr(set_adr(i), p);
         mdl[i] = mdl[i] | p;
         chk("R3 R5 R9 irq after set", 32'(irq_o), 32'(exp_irq()));
      end
      check_all("R2 R3");

      // R3: OR accumulation with a second pattern
      for (int i = 0; i < NM; i++) begin
         p = 32'h00F0_0000 >> (i % 4) | 32'(i * 3);
         wr(set_adr(i), p);
         mdl[i] = mdl[i] | p;
      end
      check_all("R3 accumulate");

      // R4: partial clear keeps unnamed bits
      for (int i = 0; i < NM; i++) begin
         p = (32'h1 << i) | 32'h0030_0000;
         wr(clr_adr(i), p);
         mdl[i] = mdl[i] & ~p;
         chk("R4 R9 irq after partial clear", 32'(irq_o), 32'(exp_irq()));
      end
      check_all("R4");

      // R8: stray writes outside windows and misaligned
      for (int a = 0; a < 128; a += 4) wr(8'(a), 32'hFFFF_FFFF);
      wr(8'h81, 32'hFFFF_FFFF);
      wr(8'hC2, 32'hFFFF_FFFF);
      wr(8'hB7, 32'hFFFF_FFFF);
      check_all("R8 stray writes");
      rd(8'h40, d);
      chk("R8 out-of-window read", d, 32'h0);
      rd(8'hC1, d);
      chk("R8 misaligned read", d, 32'h0);

      // R10: repeated reads leave contents alone
      for (int r = 0; r < 3; r++) rd(clr_adr(5), d);
      check_all("R10");

      // R5: lowest-bit acknowledge loop empties every mailbox
      for (int i = 0; i < NM; i++) begin
         while (mdl[i] != 0) begin
            rd(clr_adr(i), d);
            chk("R6 ack read", d, mdl[i]);
            p = d & (~d + 32'h1);
            wr(clr_adr(i), p);
            mdl[i] = mdl[i] & ~p;
            chk("R5 irq level during ack", 32'(irq_o), 32'(exp_irq()));
         end
      end
      chk("R5 all lines low", 32'(irq_o), 32'h0);

      // R4: clear of an empty mailbox stays empty; then set single bit
      wr(clr_adr(15), 32'hFFFF_FFFF);
      chk("R4 clear empty", 32'(irq_o), 32'h0);
      wr(set_adr(15), 32'h8000_0000);
      mdl[15] = 32'h8000_0000;
      chk("R2 top index line", 32'(irq_o), 32'h8000);
      rd(set_adr(15), d);
      chk("R7 single bit", d, 32'h8000_0000);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule